// File: doc/BRIEF.md
# Gigabit Byte-Wide Transmit Line Encoder

This block sits on the MAC side of a byte-wide gigabit media-independent link and turns an upstream frame stream into the three transmit line groups: the frame enable, the coding-error line and the 8-bit data bus. Upstream offers one byte per cycle with a valid, a last-byte and an error marker. Between frames it may also ask for carrier extension, either plain or with an error. Every line leaves the block from one register stage, clocked by the 125 MHz transmit clock that the MAC side supplies.

The encoder keeps the enable envelope unbroken from the first byte to the last. An in-frame error marker becomes the error-propagation symbol. After a frame has ended, an extension request becomes one of the two legal out-of-frame symbols. No out-of-frame combination that the line reserves can ever reach the outputs. Misuse by upstream sets a sticky flag that only reset clears. Misuse means a hole in the middle of a frame, or an extension request that does not directly follow a frame.

Top module: `gmii_tx_encoder`

## Requirements
- R1: Synchronous active-high reset drives gmii_en=0, gmii_er=0, gmii_d=0x00 and clears proto_viol.
- R2: A byte presented with in_valid=1 appears on gmii_d with gmii_en=1 one clock edge later, whatever the state; in_last=1 ends the frame after that byte, and a one-byte frame is allowed.
- R3: A byte presented with in_valid=1 and in_err=1 is driven with gmii_en=1 and gmii_er=1 (error propagation), with its data value unchanged.
- R4: Inside a frame (after a byte without in_last), a cycle with in_valid=0 keeps gmii_en=1 and drives gmii_er=1 with gmii_d=GAP_FILL (default 0x00), and it sets proto_viol.
- R5: Between frames with no accepted extension, the outputs are gmii_en=0, gmii_er=0, gmii_d=0x00.
- R6: When ALLOW_EXT=1, ext_req=1 in the cycle directly after a last byte, or in any cycle directly after an extension cycle, drives gmii_en=0 and gmii_er=1, with gmii_d=0x0F (carrier extend) when ext_err=0 and gmii_d=0x1F (carrier extend error) when ext_err=1; this does not set proto_viol.
- R7: Once ext_req drops after an extension, the next cycle is idle (R5), and extension cannot restart until another frame ends.
- R8: ext_req=1 with no extension allowed (idle, no frame just ended) is ignored, gives idle outputs, and sets proto_viol, which stays set until reset.
- R9: ext_req=1 while a byte is being sent has no effect on gmii_en, gmii_er or gmii_d, and does not set proto_viol.
- R10: in_valid=1 during an extension, even with ext_req=1, starts a new frame at once: the byte is driven as in R2.
- R11: The outputs never show gmii_en=0 and gmii_er=1 with a gmii_d value other than 0x0F or 0x1F.
- R12: With ALLOW_EXT=0, an extension request after a last byte is handled as in R8: idle outputs and proto_viol set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz transmit clock, MAC-supplied |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream byte present this cycle |
| in_data | input | 8 | Upstream byte |
| in_last | input | 1 | Byte is the final one of the frame |
| in_err | input | 1 | Byte is to be sent as corrupted |
| ext_req | input | 1 | Request one carrier-extension cycle |
| ext_err | input | 1 | Extension cycle carries the error code |
| gmii_en | output | 1 | Transmit frame enable |
| gmii_er | output | 1 | Transmit coding error line |
| gmii_d | output | 8 | Transmit data bus |
| proto_viol | output | 1 | Sticky upstream misuse flag |

## Verification
The bench builds the main instance with default parameters: extension enabled and a gap fill of 0x00. This exposes both extension codes, the hand-off from extension to a new frame, and the in-frame hole. A second instance driven by the same stimulus is built with ALLOW_EXT=0. Through it the same frame end followed by an extension request reaches the rejected variant, where it must yield idle outputs and a raised misuse flag. A single-byte frame and a reset pulse between sequences exercise the one-cycle frame and the clearing of the sticky flag.

// File: rtl/gmii_tx_pkg.sv
package gmii_tx_pkg;

    localparam int OCTET_W = 8;
    typedef logic [OCTET_W-1:0] octet_t;

    localparam octet_t CODE_IDLE    = 8'h00;
    localparam octet_t CODE_EXT     = 8'h0F;
    localparam octet_t CODE_EXT_ERR = 8'h1F;

    // Position in the frame sequence
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_TAIL  = 2'd2
    } flow_e;

    // Which symbol the line carries this cycle
    typedef enum logic [2:0] {
        K_IDLE    = 3'd0,
        K_DATA    = 3'd1,
        K_GAP     = 3'd2,
        K_EXT     = 3'd3,
        K_EXT_ERR = 3'd4
    } kind_e;

    typedef struct packed {
        logic   en;
        logic   er;
        octet_t d;
    } sym_t;

    localparam sym_t SYM_IDLE = '{en: 1'b0, er: 1'b0, d: CODE_IDLE};

    function automatic sym_t build_sym(input kind_e k, input octet_t data,
                                       input logic err, input octet_t gap_fill);
        sym_t s;
        s = SYM_IDLE;
        case (k)
            K_DATA:    s = '{en: 1'b1, er: err,  d: data};
            K_GAP:     s = '{en: 1'b1, er: 1'b1, d: gap_fill};
            K_EXT:     s = '{en: 1'b0, er: 1'b1, d: CODE_EXT};
            K_EXT_ERR: s = '{en: 1'b0, er: 1'b1, d: CODE_EXT_ERR};
            default:   s = SYM_IDLE;
        endcase
        return s;
    endfunction

    function automatic logic sym_legal(input sym_t s);
        return !(!s.en && s.er) || (s.d == CODE_EXT) || (s.d == CODE_EXT_ERR);
    endfunction

endpackage

// File: rtl/gmii_tx_flow.sv
module gmii_tx_flow
    import gmii_tx_pkg::*;
#(
    parameter bit ALLOW_EXT = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  logic  in_last,
    input  logic  ext_req,
    input  logic  ext_err,
    output kind_e kind,
    output logic  misuse,
    output logic  in_body
);

    flow_e state_q, state_n;
    logic  ext_ok;

    generate
        if (ALLOW_EXT) begin : g_ext_on
            assign ext_ok = 1'b1;
        end else begin : g_ext_off
            assign ext_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        state_n = state_q;
        kind    = K_IDLE;
        misuse  = 1'b0;
        if (in_valid) begin
            kind    = K_DATA;
            state_n = in_last ? ST_TAIL : ST_FRAME;
        end else begin
            case (state_q)
                ST_FRAME: begin
                    kind   = K_GAP;
                    misuse = 1'b1;
                end
                ST_TAIL: begin
                    if (ext_req && ext_ok) begin
                        kind = ext_err ? K_EXT_ERR : K_EXT;
                    end else begin
                        misuse  = ext_req;
                        state_n = ST_IDLE;
                    end
                end
                default: begin
                    misuse  = ext_req;
                    state_n = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    assign in_body = (state_q == ST_FRAME);

    // R7: after the tail closes without extension, the flow is idle
    p_tail_closes_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAIL && !in_valid && !ext_req) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/gmii_tx_symgen.sv
module gmii_tx_symgen
    import gmii_tx_pkg::*;
#(
    parameter octet_t GAP_FILL = 8'h00
) (
    input  kind_e  kind,
    input  octet_t data,
    input  logic   err,
    output sym_t   sym
);

    always_comb begin
        sym = build_sym(kind, data, err, GAP_FILL);
    end

    // R11: the builder never forms a reserved out-of-frame symbol
    always_comb begin
        p_legal_build_r11: assert (sym_legal(sym));
    end

endmodule

// File: rtl/gmii_tx_outreg.sv
module gmii_tx_outreg
    import gmii_tx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sym_t sym_d,
    output sym_t sym_q
);

    always_ff @(posedge clk) begin
        if (rst) sym_q <= SYM_IDLE;
        else     sym_q <= sym_d;
    end

    p_no_reserved_r11: assert property (@(posedge clk) disable iff (rst)
        (!sym_q.en && sym_q.er) |-> (sym_q.d == CODE_EXT || sym_q.d == CODE_EXT_ERR));

    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (sym_q == SYM_IDLE));

endmodule

// File: rtl/gmii_tx_flag.sv
module gmii_tx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
    end

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        flag |=> flag);

    p_set_seen_r8: assert property (@(posedge clk) disable iff (rst)
        set |=> flag);

endmodule

// File: rtl/gmii_tx_encoder.sv
module gmii_tx_encoder
    import gmii_tx_pkg::*;
#(
    parameter bit     ALLOW_EXT = 1'b1,
    parameter octet_t GAP_FILL  = 8'h00
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [7:0]   in_data,
    input  logic         in_last,
    input  logic         in_err,
    input  logic         ext_req,
    input  logic         ext_err,
    output logic         gmii_en,
    output logic         gmii_er,
    output logic [7:0]   gmii_d,
    output logic         proto_viol
);

    kind_e kind;
    logic  misuse;
    logic  in_body;
    sym_t  sym_d;
    sym_t  sym_q;

    gmii_tx_flow #(.ALLOW_EXT(ALLOW_EXT)) u_flow (
        .clk     (clk),
        .rst     (rst),
        .in_valid(in_valid),
        .in_last (in_last),
        .ext_req (ext_req),
        .ext_err (ext_err),
        .kind    (kind),
        .misuse  (misuse),
        .in_body (in_body)
    );

    gmii_tx_symgen #(.GAP_FILL(GAP_FILL)) u_symgen (
        .kind(kind),
        .data(in_data),
        .err (in_err),
        .sym (sym_d)
    );

    gmii_tx_outreg u_outreg (
        .clk  (clk),
        .rst  (rst),
        .sym_d(sym_d),
        .sym_q(sym_q)
    );

    gmii_tx_flag u_flag (
        .clk (clk),
        .rst (rst),
        .set (misuse),
        .flag(proto_viol)
    );

    assign gmii_en = sym_q.en;
    assign gmii_er = sym_q.er;
    assign gmii_d  = sym_q.d;

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (gmii_en && gmii_d == $past(in_data) && gmii_er == $past(in_err)));

    p_gap_fill_r4: assert property (@(posedge clk) disable iff (rst)
        (in_body && !in_valid) |=> (gmii_en && gmii_er && proto_viol));

    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !in_body && !ext_req) |=> (!gmii_en && !gmii_er && gmii_d == 8'h00));

    p_ext_follows_r6: assert property (@(posedge clk) disable iff (rst)
        (!gmii_en && gmii_er) |-> ($past(gmii_en) || $past(gmii_er)));

    p_idle_ext_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !in_body && ext_req && !gmii_en && !gmii_er) |=> (!gmii_en && !gmii_er && proto_viol));

endmodule

// File: tb/gmii_tx_encoder_test.sv
module gmii_tx_encoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_err = 1'b0;
    logic       ext_req = 1'b0;
    logic       ext_err = 1'b0;
    logic       gmii_en, gmii_er, proto_viol;
    logic [7:0] gmii_d;
    logic       nx_en, nx_er, nx_viol;
    logic [7:0] nx_d;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [9:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    gmii_tx_encoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_err(in_err), .ext_req(ext_req), .ext_err(ext_err),
        .gmii_en(gmii_en), .gmii_er(gmii_er), .gmii_d(gmii_d), .proto_viol(proto_viol)
    );

    gmii_tx_encoder #(.ALLOW_EXT(1'b0)) uut_noext (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_err(in_err), .ext_req(ext_req), .ext_err(ext_err),
        .gmii_en(nx_en), .gmii_er(nx_er), .gmii_d(nx_d), .proto_viol(nx_viol)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one input cycle, expected line symbol queued for the monitor
    task automatic step(input logic v, input logic [7:0] d, input logic l, input logic e,
                        input logic x, input logic xe,
                        input logic en, input logic er, input logic [7:0] ed, input string tag);
        @(negedge clk);
        in_valid = v; in_data = d; in_last = l; in_err = e; ext_req = x; ext_err = xe;
        exp_q.push_back({en, er, ed});
        tag_q.push_back(tag);
    endtask

    task automatic idle_step(input string tag);
        step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, tag);
    endtask

    // Called right after a step: look at the flag once that cycle is registered
    task automatic peek_viol(input logic exp, input string tag);
        @(posedge clk); #1;
        check(tag, {31'd0, proto_viol}, {31'd0, exp});
    endtask

    // Monitor: compares one expected symbol per registered cycle
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [9:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, {22'd0, gmii_en, gmii_er, gmii_d}, {22'd0, e});
        end
        if (!rst && !gmii_en && gmii_er)
            check("R11 reserved code", {31'd0, (gmii_d == 8'h0F || gmii_d == 8'h1F)}, 32'd1);
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 0; in_last = 0; in_err = 0; ext_req = 0; ext_err = 0;
        repeat (2) @(negedge clk);
        check("R1 reset en/er/d", {22'd0, gmii_en, gmii_er, gmii_d}, 32'd0);
        check("R1 reset viol", {31'd0, proto_viol}, 32'd0);
        rst = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        idle_step("R5 idle after reset");

        // Four-byte frame: error byte inside, extension request inside is ignored
        step(1, 8'h11, 0, 0, 0, 0, 1, 0, 8'h11, "R2 first byte");
        step(1, 8'h22, 0, 1, 0, 0, 1, 1, 8'h22, "R3 error propagation");
        step(1, 8'h33, 0, 0, 1, 0, 1, 0, 8'h33, "R9 ext in frame ignored");
        step(1, 8'h44, 1, 0, 0, 0, 1, 0, 8'h44, "R2 last byte");

        // Extension after the frame
        step(0, 8'h00, 0, 0, 1, 0, 0, 1, 8'h0F, "R6 carrier extend");
        @(posedge clk); #1;
        check("R12 noext idle", {22'd0, nx_en, nx_er, nx_d}, 32'd0);
        check("R12 noext viol", {31'd0, nx_viol}, 32'd1);
        step(0, 8'h00, 0, 0, 1, 1, 0, 1, 8'h1F, "R6 carrier extend error");
        peek_viol(1'b0, "R6/R9 no violation");

        idle_step("R7 idle after extension");
        step(0, 8'h00, 0, 0, 1, 0, 0, 0, 8'h00, "R7/R8 late ext ignored");
        peek_viol(1'b1, "R8 ext while idle flags");
        idle_step("R5 idle");
        idle_step("R5 idle");
        peek_viol(1'b1, "R8 flag sticky");

        wait (exp_q.size() == 0);
        do_reset();

        // Single-byte frame, extension, restart, hole
        step(1, 8'h9A, 1, 0, 0, 0, 1, 0, 8'h9A, "R2 single-byte frame");
        step(0, 8'h00, 0, 0, 1, 0, 0, 1, 8'h0F, "R6 extend after short frame");
        step(1, 8'h55, 0, 0, 1, 0, 1, 0, 8'h55, "R10 valid wins over ext");
        peek_viol(1'b0, "R10 no violation");
        step(0, 8'h00, 0, 0, 0, 0, 1, 1, 8'h00, "R4 hole keeps envelope");
        peek_viol(1'b1, "R4 hole flags");
        step(1, 8'h66, 1, 0, 0, 0, 1, 0, 8'h66, "R4 frame resumes");
        idle_step("R5 idle after frame");
        idle_step("R5 idle");

        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule